// File: doc/BRIEF.md
# Limited-Pointer Coherence Directory

This block is the home-side directory for a set of memory blocks in a shared-memory system. It does not keep a full presence vector for each block. Each entry instead holds a small fixed number of sharer slots. A slot is a node ID with a valid bit. Each entry also has a dirty flag, which marks a single modified owner, and an overflow flag. Requests arrive one at a time and carry an operation, an entry index and a requesting node. The operations are read miss, write miss and sharer removal.

When a request means that cached copies must be killed, the block turns the affected node IDs into a pending set. It then streams the targets out one per cycle on a valid/ready port. While that stream drains, it accepts no further requests. A parameter selects what happens when a new reader finds every slot taken:
- In broadcast mode, the entry is marked overflowed, and the next write invalidates every node.
- In victim mode, one tracked sharer is evicted by a per-entry round-robin pointer, and its slot is reused.

A read miss that finds the entry dirty reports the owner's ID for one cycle. The requester can then fetch the line from that owner.

Top module: `lptr_dir`

## Requirements
- R1: After reset, every entry has no valid slot, dirty is clear and overflow is clear. req_ready is 1, and inv_valid and fwd_valid are 0.
- R2: A read (req_op = 1) from a node that no valid slot of the entry holds stores that node in the lowest-numbered free slot, if a free slot exists.
- R3: A read from a node that a valid slot already holds leaves the entry unchanged. It produces no invalidation and does not use up another slot.
- R4: A write (req_op = 2) invalidates every node held in a valid slot of the entry, except the writer. Afterwards the entry holds only the writer, with dirty set and overflow clear.
- R5: Invalidation targets leave one per accepted handshake, in ascending node-ID order. While inv_ready is low, inv_valid stays high and inv_node holds its value.
- R6: While any invalidation target is pending, req_ready is 0.
- R7: In broadcast mode (BCAST = 1), a read from a new node that finds all PTRS slots valid sets overflow and is not recorded. The next write to that entry invalidates all NODES nodes except the writer, then clears overflow.
- R8: In victim mode (BCAST = 0), a read from a new node that finds all slots valid works as follows:
  - the slot named by the entry's round-robin pointer is chosen;
  - the node in that slot is invalidated;
  - the slot takes the new node;
  - the pointer advances, starting at slot 0 and wrapping after slot PTRS-1.
- R9: A removal (req_op = 3) clears the valid bit of the slot that holds the requesting node. If the entry is dirty and that node is its owner, dirty is cleared as well.
- R10: A read from a new node while the entry is dirty raises fwd_valid for exactly the cycle after acceptance, with fwd_node equal to the owner. The read also clears dirty and records the reader.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 2 | 0 no-op, 1 read miss, 2 write miss, 3 removal |
| req_entry | input | $clog2(ENTRIES) | Directory entry index |
| req_node | input | $clog2(NODES) | Requesting node ID |
| inv_valid | output | 1 | Invalidation target present |
| inv_ready | input | 1 | Target accepted by the network side |
| inv_node | output | $clog2(NODES) | Node to invalidate |
| fwd_valid | output | 1 | One-cycle pulse: read hit a dirty entry |
| fwd_node | output | $clog2(NODES) | Current dirty owner for that read |

## Verification
The hardest state to reach is an entry whose contents must be inferred only from the invalidations of a later write. This applies most of all to the overflowed entry in broadcast mode and to the round-robin victim position in victim mode. The stimulus fills one entry past its slot count with distinct readers. It then issues a write and compares the full set of emitted targets against a computed mask. Repeated reads from a single node are also pushed into one entry before it is filled. A duplicate record would then tip the entry into overflow and show up as a broadcast.

// File: rtl/lptr_dir_pkg.sv
package lptr_dir_pkg;
    typedef enum logic [1:0] {
        OP_NOP    = 2'd0,
        OP_READ   = 2'd1,
        OP_WRITE  = 2'd2,
        OP_REMOVE = 2'd3
    } op_e;
endpackage

// File: rtl/lptr_dir_pick.sv
// Lowest-set-bit finder.
module lptr_dir_pick #(
    parameter int W  = 16,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (vec[k]) idx = IW'(k);
        end
        any = |vec;
    end
endmodule

// File: rtl/lptr_dir_match.sv
// Slot lookup for one entry: where the node sits, and the first empty slot.
module lptr_dir_match #(
    parameter int PTRS = 4,
    parameter int NW   = 4,
    localparam int PW  = (PTRS > 1) ? $clog2(PTRS) : 1
) (
    input  logic [PTRS-1:0]         vld,
    input  logic [PTRS-1:0][NW-1:0] ptr,
    input  logic [NW-1:0]           node,
    output logic                    hit,
    output logic [PW-1:0]           hit_idx,
    output logic                    full,
    output logic [PW-1:0]           free_idx
);
    logic [PTRS-1:0] eq;
    logic            free_any;

    for (genvar g = 0; g < PTRS; g++) begin : g_cmp
        assign eq[g] = vld[g] && (ptr[g] == node);
    end

    lptr_dir_pick #(.W(PTRS)) u_hit (.vec(eq),   .any(hit),      .idx(hit_idx));
    lptr_dir_pick #(.W(PTRS)) u_free(.vec(~vld), .any(free_any), .idx(free_idx));

    assign full = !free_any;
endmodule

// File: rtl/lptr_dir.sv
module lptr_dir
    import lptr_dir_pkg::*;
#(
    parameter int NODES   = 16,
    parameter int PTRS    = 4,
    parameter int ENTRIES = 8,
    parameter bit BCAST   = 1'b1,
    localparam int NW = $clog2(NODES),
    localparam int EW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int PW = (PTRS > 1) ? $clog2(PTRS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [EW-1:0] req_entry,
    input  logic [NW-1:0] req_node,
    output logic          inv_valid,
    input  logic          inv_ready,
    output logic [NW-1:0] inv_node,
    output logic          fwd_valid,
    output logic [NW-1:0] fwd_node
);
    typedef struct packed {
        logic [PTRS-1:0]         vld;
        logic [PTRS-1:0][NW-1:0] ptr;
        logic                    dirty;
        logic                    ovf;
        logic [PW-1:0]           rr;
    } ent_t;

    typedef struct packed {
        ent_t [ENTRIES-1:0] ent;
        logic [NODES-1:0]   pend;
        logic               fwd_v;
        logic [NW-1:0]      fwd_n;
    } st_t;

    st_t  st_d, st_q;
    ent_t cur, nxt;

    logic          hit, full;
    logic [PW-1:0] hit_idx, free_idx;
    logic          inv_any;
    logic [NW-1:0] inv_idx;
    logic [NODES-1:0] wr_mask;

    assign cur = st_q.ent[req_entry];

    lptr_dir_match #(.PTRS(PTRS), .NW(NW)) u_match (
        .vld(cur.vld), .ptr(cur.ptr), .node(req_node),
        .hit(hit), .hit_idx(hit_idx), .full(full), .free_idx(free_idx)
    );

    lptr_dir_pick #(.W(NODES)) u_inv (.vec(st_q.pend), .any(inv_any), .idx(inv_idx));

    always_comb begin
        st_d       = st_q;
        nxt        = cur;
        wr_mask    = '0;
        st_d.fwd_v = 1'b0;

        if (inv_valid && inv_ready) st_d.pend[inv_idx] = 1'b0;

        if (req_valid && req_ready) begin
            unique case (op_e'(req_op))
                OP_READ: begin
                    if (!hit) begin
                        if (cur.dirty) begin
                            st_d.fwd_v = 1'b1;
                            st_d.fwd_n = cur.ptr[0];
                            nxt.dirty  = 1'b0;
                        end
                        if (!full) begin
                            nxt.vld[free_idx] = 1'b1;
                            nxt.ptr[free_idx] = req_node;
                        end else if (BCAST) begin
                            nxt.ovf = 1'b1;
                        end else begin
                            st_d.pend[cur.ptr[cur.rr]] = 1'b1;
                            nxt.ptr[cur.rr] = req_node;
                            nxt.rr = (cur.rr == PW'(PTRS - 1)) ? '0 : cur.rr + 1'b1;
                        end
                    end
                end
                OP_WRITE: begin
                    for (int k = 0; k < PTRS; k++) begin
                        if (cur.vld[k]) wr_mask[cur.ptr[k]] = 1'b1;
                    end
                    if (cur.ovf) wr_mask = '1;
                    wr_mask[req_node] = 1'b0;
                    st_d.pend  = st_d.pend | wr_mask;
                    nxt.vld    = '0;
                    nxt.vld[0] = 1'b1;
                    nxt.ptr[0] = req_node;
                    nxt.dirty  = 1'b1;
                    nxt.ovf    = 1'b0;
                end
                OP_REMOVE: begin
                    if (hit) begin
                        nxt.vld[hit_idx] = 1'b0;
                        if (cur.dirty) nxt.dirty = 1'b0;
                    end
                end
                default: ;
            endcase
            st_d.ent[req_entry] = nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready = ~|st_q.pend;
    assign inv_valid = inv_any;
    assign inv_node  = inv_idx;
    assign fwd_valid = st_q.fwd_v;
    assign fwd_node  = st_q.fwd_n;
endmodule

// File: rtl/lptr_dir_chk.sv
module lptr_dir_chk #(
    parameter int NW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [1:0]    req_op,
    input logic [NW-1:0] req_node,
    input logic          inv_valid,
    input logic          inv_ready,
    input logic [NW-1:0] inv_node,
    input logic          fwd_valid
);
    logic          wr_act;
    logic [NW-1:0] wr_node;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_act  <= 1'b0;
            wr_node <= '0;
        end else if (req_valid && req_ready) begin
            wr_act  <= (req_op == 2'd2);
            wr_node <= req_node;
        end
    end

    // R5
    inv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid && !inv_ready |=> inv_valid && $stable(inv_node));

    // R5
    inv_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid && inv_ready |=> !inv_valid || (inv_node > $past(inv_node)));

    // R4
    no_self_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid && wr_act |-> inv_node != wr_node);

    // R6
    inv_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inv_valid) |-> $past(req_valid && req_ready));

    // R10
    fwd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> $past(req_valid && req_ready && req_op == 2'd1));
endmodule

bind lptr_dir lptr_dir_chk #(.NW(NW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_node(req_node), .inv_valid(inv_valid),
    .inv_ready(inv_ready), .inv_node(inv_node), .fwd_valid(fwd_valid)
);

// File: tb/lptr_dir_tb.sv
module lptr_dir_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG = 20000;
    localparam int NROW = 38;

    // {req[34:31], vic[30], op[29:28], ent[27:25], node[24:21], mask[20:5], fv[4], fn[3:0]}
    localparam logic [34:0] TBL [NROW] = '{
        // entry 1, broadcast: fill, repeat, write, dirty forward (R2 R3 R4 R10)
        {4'd2, 1'b0, 2'd1, 3'd1, 4'd1, 16'h0000, 1'b0, 4'd0},
        {4'd2, 1'b0, 2'd1, 3'd1, 4'd2, 16'h0000, 1'b0, 4'd0},
        {4'd2, 1'b0, 2'd1, 3'd1, 4'd3, 16'h0000, 1'b0, 4'd0},
        {4'd3, 1'b0, 2'd1, 3'd1, 4'd1, 16'h0000, 1'b0, 4'd0},
        {4'd4, 1'b0, 2'd2, 3'd1, 4'd2, 16'h000A, 1'b0, 4'd0},
        {4'd10,1'b0, 2'd1, 3'd1, 4'd5, 16'h0000, 1'b1, 4'd2},
        {4'd10,1'b0, 2'd2, 3'd1, 4'd5, 16'h0004, 1'b0, 4'd0},
        // entry 2, victim mode (R8)
        {4'd2, 1'b1, 2'd1, 3'd2, 4'd0, 16'h0000, 1'b0, 4'd0},
        {4'd2, 1'b1, 2'd1, 3'd2, 4'd1, 16'h0000, 1'b0, 4'd0},
        {4'd2, 1'b1, 2'd1, 3'd2, 4'd2, 16'h0000, 1'b0, 4'd0},
        {4'd2, 1'b1, 2'd1, 3'd2, 4'd3, 16'h0000, 1'b0, 4'd0},
        {4'd8, 1'b1, 2'd1, 3'd2, 4'd4, 16'h0001, 1'b0, 4'd0},
        {4'd8, 1'b1, 2'd1, 3'd2, 4'd5, 16'h0002, 1'b0, 4'd0},
        {4'd8, 1'b1, 2'd2, 3'd2, 4'd9, 16'h003C, 1'b0, 4'd0},
        // entry 3, broadcast overflow (R7)
        {4'd7, 1'b0, 2'd1, 3'd3, 4'd0, 16'h0000, 1'b0, 4'd0},
        {4'd7, 1'b0, 2'd1, 3'd3, 4'd1, 16'h0000, 1'b0, 4'd0},
        {4'd7, 1'b0, 2'd1, 3'd3, 4'd2, 16'h0000, 1'b0, 4'd0},
        {4'd7, 1'b0, 2'd1, 3'd3, 4'd3, 16'h0000, 1'b0, 4'd0},
        {4'd7, 1'b0, 2'd1, 3'd3, 4'd4, 16'h0000, 1'b0, 4'd0},
        {4'd7, 1'b0, 2'd2, 3'd3, 4'd7, 16'hFF7F, 1'b0, 4'd0},
        {4'd7, 1'b0, 2'd2, 3'd3, 4'd8, 16'h0080, 1'b0, 4'd0},
        // entry 4, removal and owner removal (R9)
        {4'd9, 1'b0, 2'd1, 3'd4, 4'd3, 16'h0000, 1'b0, 4'd0},
        {4'd9, 1'b0, 2'd1, 3'd4, 4'd6, 16'h0000, 1'b0, 4'd0},
        {4'd9, 1'b0, 2'd3, 3'd4, 4'd3, 16'h0000, 1'b0, 4'd0},
        {4'd9, 1'b0, 2'd2, 3'd4, 4'd6, 16'h0000, 1'b0, 4'd0},
        {4'd4, 1'b0, 2'd2, 3'd4, 4'd10,16'h0040, 1'b0, 4'd0},
        {4'd9, 1'b0, 2'd3, 3'd4, 4'd10,16'h0000, 1'b0, 4'd0},
        {4'd9, 1'b0, 2'd1, 3'd4, 4'd12,16'h0000, 1'b0, 4'd0},
        {4'd9, 1'b0, 2'd2, 3'd4, 4'd13,16'h1000, 1'b0, 4'd0},
        // entry 5, repeated reader must not overflow (R3)
        {4'd3, 1'b0, 2'd1, 3'd5, 4'd1, 16'h0000, 1'b0, 4'd0},
        {4'd3, 1'b0, 2'd1, 3'd5, 4'd1, 16'h0000, 1'b0, 4'd0},
        {4'd3, 1'b0, 2'd1, 3'd5, 4'd1, 16'h0000, 1'b0, 4'd0},
        {4'd3, 1'b0, 2'd1, 3'd5, 4'd1, 16'h0000, 1'b0, 4'd0},
        {4'd3, 1'b0, 2'd1, 3'd5, 4'd1, 16'h0000, 1'b0, 4'd0},
        {4'd3, 1'b0, 2'd1, 3'd5, 4'd2, 16'h0000, 1'b0, 4'd0},
        {4'd3, 1'b0, 2'd1, 3'd5, 4'd3, 16'h0000, 1'b0, 4'd0},
        {4'd3, 1'b0, 2'd1, 3'd5, 4'd4, 16'h0000, 1'b0, 4'd0},
        {4'd3, 1'b0, 2'd2, 3'd5, 4'd9, 16'h001E, 1'b0, 4'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_v = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = '0;
    logic [2:0] req_entry = '0;
    logic [3:0] req_node = '0;
    logic       inv_rdy = 1'b1;

    logic       b_ready, b_inv_valid, b_fwd_valid;
    logic [3:0] b_inv_node, b_fwd_node;
    logic       v_ready, v_inv_valid, v_fwd_valid;
    logic [3:0] v_inv_node, v_fwd_node;

    logic       o_ready, o_inv_valid, o_fwd_valid;
    logic [3:0] o_inv_node, o_fwd_node;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lptr_dir #(.BCAST(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid && !sel_v), .req_ready(b_ready),
        .req_op(req_op), .req_entry(req_entry), .req_node(req_node),
        .inv_valid(b_inv_valid), .inv_ready(inv_rdy && !sel_v), .inv_node(b_inv_node),
        .fwd_valid(b_fwd_valid), .fwd_node(b_fwd_node)
    );

    lptr_dir #(.BCAST(1'b0)) u_vic (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid && sel_v), .req_ready(v_ready),
        .req_op(req_op), .req_entry(req_entry), .req_node(req_node),
        .inv_valid(v_inv_valid), .inv_ready(inv_rdy && sel_v), .inv_node(v_inv_node),
        .fwd_valid(v_fwd_valid), .fwd_node(v_fwd_node)
    );

    assign o_ready     = sel_v ? v_ready     : b_ready;
    assign o_inv_valid = sel_v ? v_inv_valid : b_inv_valid;
    assign o_inv_node  = sel_v ? v_inv_node  : b_inv_node;
    assign o_fwd_valid = sel_v ? v_fwd_valid : b_fwd_valid;
    assign o_fwd_node  = sel_v ? v_fwd_node  : b_fwd_node;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic do_req(input logic vic, input logic [1:0] op, input logic [2:0] ent,
                          input logic [3:0] node, output logic fv, output logic [3:0] fn);
        @(negedge clk);
        sel_v = vic;
        while (!o_ready) @(negedge clk);
        req_op = op; req_entry = ent; req_node = node; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        fv = o_fwd_valid;
        fn = o_fwd_node;
    endtask

    task automatic collect(output logic [15:0] m, output logic ordered);
        int last = -1;
        int guard = 0;
        m = '0;
        ordered = 1'b1;
        while (o_inv_valid && guard < 40) begin
            if (int'(o_inv_node) <= last) ordered = 1'b0;
            last = int'(o_inv_node);
            m[o_inv_node] = 1'b1;
            guard++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run hung actual=running expected=done");
        summary();
    end

    initial begin
        logic       fv, ord;
        logic [3:0] fn;
        logic [15:0] m;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at the ports of both variants
        chk(b_ready && !b_inv_valid && !b_fwd_valid, "R1 broadcast idle", {29'd0, b_ready, b_inv_valid, b_fwd_valid}, 32'h4);
        chk(v_ready && !v_inv_valid && !v_fwd_valid, "R1 victim idle", {29'd0, v_ready, v_inv_valid, v_fwd_valid}, 32'h4);
        // R1: first write to an entry finds no sharers
        do_req(1'b0, 2'd2, 3'd0, 4'd0, fv, fn);
        collect(m, ord);
        chk(m == 16'h0, "R1 empty entry write", {16'd0, m}, 32'h0);
        do_req(1'b1, 2'd2, 3'd0, 4'd0, fv, fn);
        collect(m, ord);
        chk(m == 16'h0, "R1 empty victim entry write", {16'd0, m}, 32'h0);

        for (int r = 0; r < NROW; r++) begin
            logic [34:0] row = TBL[r];
            string tag = $sformatf("R%0d row %0d", row[34:31], r);
            do_req(row[30], row[29:28], row[27:25], row[24:21], fv, fn);
            chk(fv == row[4] && (!row[4] || fn == row[3:0]), {tag, " fwd"},
                {27'd0, fv, fn}, {27'd0, row[4:0]});
            collect(m, ord);
            chk(m == row[20:5], {tag, " targets"}, {16'd0, m}, {16'd0, row[20:5]});
            chk(ord, {tag, " R5 ascending order"}, {31'd0, ord}, 32'h1);
        end

        // R5 R6: backpressure on the invalidation stream, entry 6
        do_req(1'b0, 2'd1, 3'd6, 4'd2, fv, fn);
        do_req(1'b0, 2'd1, 3'd6, 4'd5, fv, fn);
        inv_rdy = 1'b0;
        do_req(1'b0, 2'd2, 3'd6, 4'd9, fv, fn);
        for (int c = 0; c < 3; c++) begin
            chk(o_inv_valid && o_inv_node == 4'd2, "R5 target held under backpressure",
                {27'd0, o_inv_valid, o_inv_node}, {27'd0, 1'b1, 4'd2});
            chk(!o_ready, "R6 request stalled while targets pending", {31'd0, o_ready}, 32'h0);
            @(negedge clk);
        end
        inv_rdy = 1'b1;
        collect(m, ord);
        chk(m == 16'h0024, "R5 stream after release", {16'd0, m}, 32'h24);
        chk(o_ready, "R6 ready after drain", {31'd0, o_ready}, 32'h1);

        summary();
    end
endmodule